// File: doc/BRIEF.md
# Multi-Zone External Bus Sequencer

This block drives an external parallel memory bus that is split into several chip-select zones. Each zone is configured as either a 16-bit or a 32-bit device, and each has its own lead, active and trail phase lengths. On-chip logic hands the sequencer one read or write at a time, giving a zone number, an address and write data. The sequencer lowers that zone's chip select and pulses the read or write strobe in the active phase. Read data comes back with a one-cycle completion pulse.

The block has one pin whose meaning depends on the width of the zone being accessed. For a 16-bit zone it carries address bit 0. For a 32-bit zone it is the write strobe for the upper halfword. A change of meaning must never look like a write edge to a 32-bit device, so the pin is parked high in every cycle with no access. An optional bank-switch gap also inserts a programmable number of quiet cycles when an access targets a different zone from the one before it. All pad outputs come straight from flops.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, every chip select, the read strobe, the write strobe and the shared pin are high, the data bus is not driven, `req_ready` is high and `rsp_done` is low. Every zone behaves as a 16-bit zone with lead 1, active 1 and trail 0.
- R2: A zone size code of 2'b01 selects 32-bit width. Every other code (0, 2, 3) selects 16-bit width.
- R3: During an access to a 16-bit zone, the shared pin equals bit 0 of the request address in every lead, active and trail cycle. During an access to a 32-bit zone, the shared pin is low exactly in the active cycles of a write and high in all other cycles.
- R4: In every cycle in which no chip select is low (idle, bank gap, completion), the shared pin, the read strobe and the write strobe are high and the data bus is not driven.
- R5: An access keeps its zone's chip select low for lead, then active, then trail cycles. Lead and active last max(value,1) cycles and trail lasts its programmed value. The strobe for the access (read or write) is low only in the active cycles.
- R6: A write to a 32-bit zone has at least one trail cycle, even when the zone's trail value is 0.
- R7: When bank switching is enabled with a gap G>0, an access to a zone different from the previous access's zone is preceded by exactly G cycles with every chip select high. No gap cycles occur for the same zone, when switching is disabled, or for the first access after reset.
- R8: `req_ready` is high only when the sequencer is idle, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge. The cycle after the last trail cycle (or after the last active cycle when trail is 0) shows a single-cycle `rsp_done`. For a read, `rsp_rdata` then holds `ext_din` as sampled in the last active cycle: the full word for a 32-bit zone, or the lower halfword zero-extended for a 16-bit zone.
- R9: For a write, `ext_doe` is high in every lead, active and trail cycle. `ext_dout` then holds the full word for a 32-bit zone, or the lower halfword with the upper 16 bits zero for a 16-bit zone. `ext_doe` is low for reads.
- R10: During an access, `ext_addr` carries request address bits [15:1].
- R11: At most one chip select is low in any cycle. While a 32-bit zone's chip select is low, the shared pin never falls unless the write strobe is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one zone's configuration |
| cfg_zone | input | 2 | Zone whose configuration is written |
| cfg_size | input | 2 | Size code (2'b01 = 32-bit, otherwise 16-bit) |
| cfg_lead | input | 3 | Lead phase length |
| cfg_active | input | 3 | Active phase length |
| cfg_trail | input | 3 | Trail phase length |
| cfg_bank_we | input | 1 | Write strobe for the bank-switch settings |
| cfg_bank_en | input | 1 | Enables idle cycles on a zone change |
| cfg_bank_gap | input | 3 | Number of idle cycles on a zone change |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | 2 | Target zone |
| req_addr | input | 16 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data |
| ext_cs_n | output | 4 | Zone chip selects, active low |
| ext_addr | output | 15 | External address lines above bit 0 |
| ext_shared | output | 1 | Address bit 0 (16-bit zone) or upper write strobe (32-bit zone) |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_dout | output | 32 | Data bus, outbound |
| ext_doe | output | 1 | Data bus output enable |
| ext_din | input | 32 | Data bus, inbound |

## Verification
The hardest case is back-to-back accesses between a 16-bit zone and a 32-bit zone with the shared pin at opposite levels on each side. A false write edge can only appear at that handover, and only when no parking or gap keeps the two apart. The stimulus therefore pairs directed sequences with random runs. The directed sequences alternate a 16-bit access with address bit 0 low and a 32-bit write or read. They also toggle bank switching and use zero phase values. The random runs reprogram zone sizes (including the unused codes), phase lengths and the gap between bursts of accesses. A free-running monitor watches every cycle for a falling shared pin under a selected 32-bit zone without a write strobe.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_LEAD,
      ST_ACTIVE,
      ST_TRAIL,
      ST_DONE
   } seq_state_e;

   localparam logic [1:0] SIZE_WIDE   = 2'b01;
   localparam logic [1:0] SIZE_NARROW = 2'b11;

   function automatic logic size_is_wide(input logic [1:0] code);
      return code == SIZE_WIDE;
   endfunction

endpackage

// File: rtl/ebs_zone_cfg.sv
module ebs_zone_cfg #(
   parameter int NUM_ZONES = 4,
   parameter int ZW        = 2,
   parameter int PH_W      = 3,
   parameter int GAP_W     = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [ZW-1:0]                     cfg_zone,
   input  logic [1:0]                        cfg_size,
   input  logic [PH_W-1:0]                   cfg_lead,
   input  logic [PH_W-1:0]                   cfg_active,
   input  logic [PH_W-1:0]                   cfg_trail,
   input  logic                              cfg_bank_we,
   input  logic                              cfg_bank_en,
   input  logic [GAP_W-1:0]                  cfg_bank_gap,
   output logic [NUM_ZONES-1:0]              zone_wide,
   output logic [NUM_ZONES-1:0][PH_W-1:0]    zone_lead,
   output logic [NUM_ZONES-1:0][PH_W-1:0]    zone_act,
   output logic [NUM_ZONES-1:0][PH_W-1:0]    zone_trail,
   output logic                              bank_en,
   output logic [GAP_W-1:0]                  bank_gap
);
   import ebs_pkg::*;

   for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
      logic [1:0]      size_q;
      logic [PH_W-1:0] lead_q, act_q, trail_q;
      logic            hit;

      assign hit = cfg_we && (cfg_zone == ZW'(z));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q  <= SIZE_NARROW;
            lead_q  <= '0;
            act_q   <= '0;
            trail_q <= '0;
         end else if (hit) begin
            size_q  <= cfg_size;
            lead_q  <= cfg_lead;
            act_q   <= cfg_active;
            trail_q <= cfg_trail;
         end
      end

      assign zone_wide[z]  = size_is_wide(size_q);
      assign zone_lead[z]  = lead_q;
      assign zone_act[z]   = act_q;
      assign zone_trail[z] = trail_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_en  <= 1'b0;
         bank_gap <= '0;
      end else if (cfg_bank_we) begin
         bank_en  <= cfg_bank_en;
         bank_gap <= cfg_bank_gap;
      end
   end

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq #(
   parameter int NUM_ZONES = 4,
   parameter int ZW        = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int PH_W      = 3,
   parameter int GAP_W     = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic                              req_write,
   input  logic [ZW-1:0]                     req_zone,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [DATA_W-1:0]                 req_wdata,
   output logic                              req_ready,
   input  logic [NUM_ZONES-1:0]              zone_wide,
   input  logic [NUM_ZONES-1:0][PH_W-1:0]    zone_lead,
   input  logic [NUM_ZONES-1:0][PH_W-1:0]    zone_act,
   input  logic [NUM_ZONES-1:0][PH_W-1:0]    zone_trail,
   input  logic                              bank_en,
   input  logic [GAP_W-1:0]                  bank_gap,
   input  logic [DATA_W-1:0]                 ext_din,
   output ebs_pkg::seq_state_e               state_d,
   output logic [ZW-1:0]                     nx_zone,
   output logic                              nx_write,
   output logic                              nx_wide,
   output logic [ADDR_W-1:0]                 nx_addr,
   output logic [DATA_W-1:0]                 nx_wdata,
   output logic                              acc_wide,
   output logic                              acc_write,
   output logic                              rsp_done,
   output logic [DATA_W-1:0]                 rsp_rdata
);
   import ebs_pkg::*;

   localparam int CNT_W  = (PH_W > GAP_W) ? PH_W : GAP_W;
   localparam int HALF_W = DATA_W / 2;

   seq_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic                accept, rd_load, need_gap;
   logic [ZW-1:0]       zone_q, last_zone_q;
   logic                last_vld_q, write_q, wide_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [PH_W-1:0]     lead_q, act_q, trail_q;
   logic [PH_W-1:0]     req_lead_e, req_act_e, req_trail_e;
   logic                req_wide;

   // effective phase lengths of the requested zone
   always_comb begin
      req_wide    = zone_wide[req_zone];
      req_lead_e  = (zone_lead[req_zone] == '0) ? PH_W'(1) : zone_lead[req_zone];
      req_act_e   = (zone_act[req_zone] == '0) ? PH_W'(1) : zone_act[req_zone];
      req_trail_e = zone_trail[req_zone];
      if (req_trail_e == '0 && req_wide && req_write) req_trail_e = PH_W'(1);
      need_gap    = bank_en && last_vld_q && (req_zone != last_zone_q) && (bank_gap != '0);
   end

   assign req_ready = (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      accept  = 1'b0;
      rd_load = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (need_gap) begin
                  state_d = ST_GAP;
                  cnt_d   = CNT_W'(bank_gap - 1'b1);
               end else begin
                  state_d = ST_LEAD;
                  cnt_d   = CNT_W'(req_lead_e - 1'b1);
               end
            end
         end
         ST_GAP: begin
            if (cnt_q == '0) begin
               state_d = ST_LEAD;
               cnt_d   = CNT_W'(lead_q - 1'b1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_LEAD: begin
            if (cnt_q == '0) begin
               state_d = ST_ACTIVE;
               cnt_d   = CNT_W'(act_q - 1'b1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_ACTIVE: begin
            if (cnt_q == '0) begin
               rd_load = !write_q;
               if (trail_q != '0) begin
                  state_d = ST_TRAIL;
                  cnt_d   = CNT_W'(trail_q - 1'b1);
               end else begin
                  state_d = ST_DONE;
               end
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_TRAIL: begin
            if (cnt_q == '0) state_d = ST_DONE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         zone_q      <= '0;
         write_q     <= 1'b0;
         wide_q      <= 1'b0;
         addr_q      <= '0;
         wdata_q     <= '0;
         lead_q      <= PH_W'(1);
         act_q       <= PH_W'(1);
         trail_q     <= '0;
         last_zone_q <= '0;
         last_vld_q  <= 1'b0;
         rsp_done    <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         state_q  <= state_d;
         cnt_q    <= cnt_d;
         rsp_done <= (state_d == ST_DONE);
         if (accept) begin
            zone_q      <= req_zone;
            write_q     <= req_write;
            wide_q      <= req_wide;
            addr_q      <= req_addr;
            wdata_q     <= req_wdata;
            lead_q      <= req_lead_e;
            act_q       <= req_act_e;
            trail_q     <= req_trail_e;
            last_zone_q <= req_zone;
            last_vld_q  <= 1'b1;
         end
         if (rd_load) begin
            rsp_rdata <= wide_q ? ext_din : {{(DATA_W-HALF_W){1'b0}}, ext_din[HALF_W-1:0]};
         end
      end
   end

   assign nx_zone   = accept ? req_zone  : zone_q;
   assign nx_write  = accept ? req_write : write_q;
   assign nx_wide   = accept ? req_wide  : wide_q;
   assign nx_addr   = accept ? req_addr  : addr_q;
   assign nx_wdata  = accept ? req_wdata : wdata_q;
   assign acc_wide  = wide_q;
   assign acc_write = write_q;

   assert_gap_needs_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> bank_en);

   assert_take_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/ebs_pad_drive.sv
module ebs_pad_drive #(
   parameter int NUM_ZONES = 4,
   parameter int ZW        = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  ebs_pkg::seq_state_e     state_d,
   input  logic [ZW-1:0]           nx_zone,
   input  logic                    nx_write,
   input  logic                    nx_wide,
   input  logic [ADDR_W-1:0]       nx_addr,
   input  logic [DATA_W-1:0]       nx_wdata,
   output logic [NUM_ZONES-1:0]    ext_cs_n,
   output logic [ADDR_W-2:0]       ext_addr,
   output logic                    ext_shared,
   output logic                    ext_rd_n,
   output logic                    ext_we_n,
   output logic [DATA_W-1:0]       ext_dout,
   output logic                    ext_doe
);
   import ebs_pkg::*;

   localparam int HALF_W = DATA_W / 2;

   logic in_acc, strobe, shared_d;

   always_comb begin
      in_acc   = (state_d == ST_LEAD) || (state_d == ST_ACTIVE) || (state_d == ST_TRAIL);
      strobe   = (state_d == ST_ACTIVE);
      // parked high whenever no zone is selected
      if (!in_acc)      shared_d = 1'b1;
      else if (nx_wide) shared_d = !(strobe && nx_write);
      else              shared_d = nx_addr[0];
   end

   for (genvar z = 0; z < NUM_ZONES; z++) begin : g_cs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_cs_n[z] <= 1'b1;
         else        ext_cs_n[z] <= !(in_acc && (nx_zone == ZW'(z)));
      end
   end

   for (genvar l = 0; l < 2; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ext_dout[l*HALF_W +: HALF_W] <= '0;
         end else if (l == 0) begin
            ext_dout[l*HALF_W +: HALF_W] <= nx_wdata[l*HALF_W +: HALF_W];
         end else begin
            ext_dout[l*HALF_W +: HALF_W] <= nx_wide ? nx_wdata[l*HALF_W +: HALF_W] : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_addr   <= '0;
         ext_shared <= 1'b1;
         ext_rd_n   <= 1'b1;
         ext_we_n   <= 1'b1;
         ext_doe    <= 1'b0;
      end else begin
         ext_addr   <= nx_addr[ADDR_W-1:1];
         ext_shared <= shared_d;
         ext_rd_n   <= !(strobe && !nx_write);
         ext_we_n   <= !(strobe && nx_write);
         ext_doe    <= in_acc && nx_write;
      end
   end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
   parameter int NUM_ZONES = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int PH_W      = 3,
   parameter int GAP_W     = 3,
   localparam int ZW       = $clog2(NUM_ZONES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [ZW-1:0]          cfg_zone,
   input  logic [1:0]             cfg_size,
   input  logic [PH_W-1:0]        cfg_lead,
   input  logic [PH_W-1:0]        cfg_active,
   input  logic [PH_W-1:0]        cfg_trail,
   input  logic                   cfg_bank_we,
   input  logic                   cfg_bank_en,
   input  logic [GAP_W-1:0]       cfg_bank_gap,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ZW-1:0]          req_zone,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rsp_done,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic [NUM_ZONES-1:0]   ext_cs_n,
   output logic [ADDR_W-2:0]      ext_addr,
   output logic                   ext_shared,
   output logic                   ext_rd_n,
   output logic                   ext_we_n,
   output logic [DATA_W-1:0]      ext_dout,
   output logic                   ext_doe,
   input  logic [DATA_W-1:0]      ext_din
);
   import ebs_pkg::*;

   if (NUM_ZONES < 2 || (1 << ZW) != NUM_ZONES) begin : g_bad_zones
      $error("NUM_ZONES must be a power of two, at least 2");
   end
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("DATA_W must be even");
   end
   if (ADDR_W < 2 || PH_W < 1 || GAP_W < 1) begin : g_bad_width
      $error("ADDR_W must be at least 2, phase and gap widths at least 1");
   end

   logic [NUM_ZONES-1:0]           zone_wide;
   logic [NUM_ZONES-1:0][PH_W-1:0] zone_lead, zone_act, zone_trail;
   logic                           bank_en;
   logic [GAP_W-1:0]               bank_gap;
   seq_state_e                     state_d;
   logic [ZW-1:0]                  nx_zone;
   logic                           nx_write, nx_wide, acc_wide, acc_write;
   logic [ADDR_W-1:0]              nx_addr;
   logic [DATA_W-1:0]              nx_wdata;

   ebs_zone_cfg #(
      .NUM_ZONES(NUM_ZONES), .ZW(ZW), .PH_W(PH_W), .GAP_W(GAP_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_size(cfg_size),
      .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
      .cfg_bank_we(cfg_bank_we), .cfg_bank_en(cfg_bank_en), .cfg_bank_gap(cfg_bank_gap),
      .zone_wide(zone_wide), .zone_lead(zone_lead), .zone_act(zone_act),
      .zone_trail(zone_trail), .bank_en(bank_en), .bank_gap(bank_gap)
   );

   ebs_seq #(
      .NUM_ZONES(NUM_ZONES), .ZW(ZW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PH_W(PH_W), .GAP_W(GAP_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_zone(req_zone),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .zone_wide(zone_wide), .zone_lead(zone_lead), .zone_act(zone_act),
      .zone_trail(zone_trail), .bank_en(bank_en), .bank_gap(bank_gap),
      .ext_din(ext_din), .state_d(state_d), .nx_zone(nx_zone),
      .nx_write(nx_write), .nx_wide(nx_wide), .nx_addr(nx_addr),
      .nx_wdata(nx_wdata), .acc_wide(acc_wide), .acc_write(acc_write),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   ebs_pad_drive #(
      .NUM_ZONES(NUM_ZONES), .ZW(ZW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_pads (
      .clk(clk), .rst_n(rst_n), .state_d(state_d), .nx_zone(nx_zone),
      .nx_write(nx_write), .nx_wide(nx_wide), .nx_addr(nx_addr),
      .nx_wdata(nx_wdata), .ext_cs_n(ext_cs_n), .ext_addr(ext_addr),
      .ext_shared(ext_shared), .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n),
      .ext_dout(ext_dout), .ext_doe(ext_doe)
   );

   assert_cs_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));

   assert_no_false_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ext_shared) && acc_wide && !(&ext_cs_n)) |-> !ext_we_n);

   assert_quiet_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (&ext_cs_n) |-> (ext_shared && ext_rd_n && ext_we_n && !ext_doe));

   assert_strobe_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n || !ext_we_n) |-> !(&ext_cs_n));

   assert_wide_write_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ext_we_n) && acc_wide && acc_write) |-> !(&ext_cs_n));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_zone = '0;
   logic [1:0]  cfg_size = '0;
   logic [2:0]  cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
   logic        cfg_bank_we = 1'b0, cfg_bank_en = 1'b0;
   logic [2:0]  cfg_bank_gap = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_ready;
   logic [1:0]  req_zone = '0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic [3:0]  ext_cs_n;
   logic [14:0] ext_addr;
   logic        ext_shared, ext_rd_n, ext_we_n, ext_doe;
   logic [31:0] ext_dout;
   logic [31:0] ext_din = '0;

   int n_checks = 0;
   int n_fail = 0;
   int mon_bad = 0;
   bit finished = 1'b0;

   logic [1:0] m_size [4];
   logic [2:0] m_lead [4];
   logic [2:0] m_act  [4];
   logic [2:0] m_trail[4];
   logic       m_bank_en;
   logic [2:0] m_gap;
   logic [1:0] m_last;
   logic       m_last_vld;

   always #(CLK_P/2) clk = ~clk;

   ext_bus_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_size(cfg_size),
      .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
      .cfg_bank_we(cfg_bank_we), .cfg_bank_en(cfg_bank_en), .cfg_bank_gap(cfg_bank_gap),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_zone(req_zone), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_shared(ext_shared),
      .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_dout(ext_dout),
      .ext_doe(ext_doe), .ext_din(ext_din)
   );

   function automatic bit f_wide(input logic [1:0] s);
      return s == 2'b01;
   endfunction

   function automatic int f_len(input logic [2:0] v);
      return (v == 3'd0) ? 1 : int'(v);
   endfunction

   function automatic int f_trail(input logic [1:0] z, input logic w);
      if (m_trail[z] == 3'd0 && f_wide(m_size[z]) && w) return 1;
      return int'(m_trail[z]);
   endfunction

   function automatic int f_gap(input logic [1:0] z);
      if (m_bank_en && m_last_vld && (z != m_last) && m_gap != 3'd0) return int'(m_gap);
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R11 monitor: shared pin falling under a selected wide zone needs the write strobe
   logic mon_prev = 1'b1;
   always @(negedge clk) begin
      logic [3:0] wmask;
      for (int z = 0; z < 4; z++) wmask[z] = f_wide(m_size[z]);
      if (rst_n && mon_prev && !ext_shared && ((~ext_cs_n & wmask) != 4'b0) && ext_we_n)
         mon_bad++;
      mon_prev = ext_shared;
   end

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      cfg_we = 1'b0;
      cfg_bank_we = 1'b0;
      for (int z = 0; z < 4; z++) begin
         m_size[z] = 2'b11; m_lead[z] = '0; m_act[z] = '0; m_trail[z] = '0;
      end
      m_bank_en = 1'b0; m_gap = '0; m_last = '0; m_last_vld = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ext_cs_n == 4'hF && ext_rd_n && ext_we_n && ext_shared && !ext_doe,
          "R1", "pins after reset", {ext_cs_n, ext_rd_n, ext_we_n, ext_shared, ext_doe}, 32'hFE);
      chk(req_ready && !rsp_done, "R1", "ready/done after reset", {req_ready, rsp_done}, 32'h2);
   endtask

   task automatic set_zone(input logic [1:0] z, input logic [1:0] s,
                           input logic [2:0] l, input logic [2:0] a, input logic [2:0] t);
      @(negedge clk);
      cfg_we = 1'b1; cfg_zone = z; cfg_size = s;
      cfg_lead = l; cfg_active = a; cfg_trail = t;
      @(negedge clk);
      cfg_we = 1'b0;
      m_size[z] = s; m_lead[z] = l; m_act[z] = a; m_trail[z] = t;
   endtask

   task automatic set_bank(input logic en, input logic [2:0] g);
      @(negedge clk);
      cfg_bank_we = 1'b1; cfg_bank_en = en; cfg_bank_gap = g;
      @(negedge clk);
      cfg_bank_we = 1'b0;
      m_bank_en = en; m_gap = g;
   endtask

   task automatic do_acc(input logic [1:0] z, input logic w, input logic [15:0] a,
                         input logic [31:0] wd, input logic [31:0] din);
      int g_exp, l_exp, a_exp, t_exp;
      int n_gap, n_lead, n_act, n_trail, n_cyc;
      bit wide, seen_done, pin_ok, quiet_ok, addr_ok, dout_ok, sel_ok, busy_ok;
      bit strobe_on, wrong, exp_pin;
      logic [31:0] rd, exp_dout, exp_rd;
      wide = f_wide(m_size[z]);
      g_exp = f_gap(z); l_exp = f_len(m_lead[z]); a_exp = f_len(m_act[z]); t_exp = f_trail(z, w);
      exp_dout = wide ? wd : {16'h0, wd[15:0]};
      exp_rd   = wide ? din : {16'h0, din[15:0]};
      n_gap = 0; n_lead = 0; n_act = 0; n_trail = 0; n_cyc = 0;
      seen_done = 0; pin_ok = 1; quiet_ok = 1; addr_ok = 1; dout_ok = 1; sel_ok = 1; busy_ok = 1;
      rd = '0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready when idle", {31'b0, req_ready}, 32'h1);
      req_valid = 1'b1; req_write = w; req_zone = z; req_addr = a; req_wdata = wd; ext_din = din;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!seen_done && n_cyc < 80) begin
         n_cyc++;
         if (req_ready) busy_ok = 0;
         if (rsp_done) begin
            seen_done = 1;
            rd = rsp_rdata;
            if (ext_cs_n != 4'hF || !ext_shared || !ext_rd_n || !ext_we_n || ext_doe) quiet_ok = 0;
         end else if (ext_cs_n == 4'hF) begin
            if (n_lead + n_act + n_trail == 0) n_gap++;
            else sel_ok = 0;
            if (!ext_shared || !ext_rd_n || !ext_we_n || ext_doe) quiet_ok = 0;
         end else begin
            if (ext_cs_n != ~(4'b0001 << z)) sel_ok = 0;
            strobe_on = w ? !ext_we_n : !ext_rd_n;
            wrong     = w ? !ext_rd_n : !ext_we_n;
            if (wrong) sel_ok = 0;
            exp_pin = wide ? !(strobe_on && w) : a[0];
            if (ext_shared != exp_pin) pin_ok = 0;
            if (ext_addr != a[15:1]) addr_ok = 0;
            if (w) begin
               if (!ext_doe || ext_dout != exp_dout) dout_ok = 0;
            end else if (ext_doe) dout_ok = 0;
            if (strobe_on) begin
               if (n_trail != 0) sel_ok = 0;
               n_act++;
            end else if (n_act == 0) n_lead++;
            else n_trail++;
         end
         if (!seen_done) @(negedge clk);
      end
      chk(seen_done, "R8", "done pulse seen", {31'b0, seen_done}, 32'h1);
      chk(busy_ok, "R8", "ready low while busy", {31'b0, busy_ok}, 32'h1);
      chk(n_gap == g_exp, "R7", "bank gap cycles", 32'(n_gap), 32'(g_exp));
      chk(n_lead == l_exp, "R5", "lead cycles", 32'(n_lead), 32'(l_exp));
      chk(n_act == a_exp, "R5", "active cycles", 32'(n_act), 32'(a_exp));
      if (wide && w && m_trail[z] == 3'd0)
         chk(n_trail == t_exp, "R6", "forced trail on wide write", 32'(n_trail), 32'(t_exp));
      else
         chk(n_trail == t_exp, "R5", "trail cycles", 32'(n_trail), 32'(t_exp));
      chk(pin_ok, "R3", "shared pin level", {31'b0, pin_ok}, 32'h1);
      chk(quiet_ok, "R4", "pins without selection", {31'b0, quiet_ok}, 32'h1);
      chk(addr_ok, "R10", "address lines", {17'b0, ext_addr}, {17'b0, a[15:1]});
      chk(dout_ok, "R9", "write data drive", ext_dout, exp_dout);
      chk(sel_ok, "R11", "single chip select", {28'b0, ext_cs_n}, {28'b0, ~(4'b0001 << z)});
      if (!w) chk(rd == exp_rd, "R8", "read data", rd, exp_rd);
      m_last = z; m_last_vld = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL R8 watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1: default zones act as 16-bit with lead 1, active 1, trail 0
      do_acc(2'd0, 1'b0, 16'h1235, 32'h0, 32'hA5A5_5A5A);
      do_acc(2'd1, 1'b1, 16'h0100, 32'hDEAD_BEEF, 32'h0);
      // R2/R6: wide zone, zero trail, write then read
      set_zone(2'd1, 2'b01, 3'd2, 3'd3, 3'd0);
      do_acc(2'd1, 1'b1, 16'h0040, 32'h1234_5678, 32'h0);
      do_acc(2'd1, 1'b0, 16'h0041, 32'h0, 32'hCAFE_F00D);
      // R2: unused codes behave as 16-bit
      set_zone(2'd2, 2'b10, 3'd1, 3'd2, 3'd2);
      set_zone(2'd3, 2'b00, 3'd0, 3'd0, 3'd1);
      do_acc(2'd2, 1'b1, 16'h0003, 32'hFFFF_8001, 32'h0);
      do_acc(2'd3, 1'b0, 16'h0002, 32'h0, 32'h8765_4321);
      // R11 handover: narrow with A0 low, then wide write and read back to back
      do_acc(2'd2, 1'b0, 16'h0010, 32'h0, 32'h1111_2222);
      do_acc(2'd1, 1'b1, 16'h0011, 32'h0BAD_CAFE, 32'h0);
      do_acc(2'd2, 1'b1, 16'h0020, 32'h0000_00FF, 32'h0);
      do_acc(2'd1, 1'b0, 16'h0021, 32'h0, 32'h7777_8888);
      // R7: bank gap on zone change, none on same zone, none when disabled
      set_bank(1'b1, 3'd3);
      do_acc(2'd2, 1'b0, 16'h0030, 32'h0, 32'h0);
      do_acc(2'd2, 1'b1, 16'h0031, 32'h5555_AAAA, 32'h0);
      do_acc(2'd1, 1'b1, 16'h0032, 32'h3333_4444, 32'h0);
      set_bank(1'b0, 3'd5);
      do_acc(2'd0, 1'b0, 16'h0033, 32'h0, 32'h9999_0000);
      // R7/R1: first access after reset has no gap; config back to defaults
      do_reset();
      set_bank(1'b1, 3'd4);
      do_acc(2'd1, 1'b1, 16'h0005, 32'h1357_9BDF, 32'h0);
      do_acc(2'd3, 1'b0, 16'h0006, 32'h0, 32'h2468_ACE0);
      // random traffic
      for (int i = 0; i < 160; i++) begin
         if (i % 8 == 0) begin
            set_zone(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                     3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                     3'($urandom_range(0, 7)));
         end
         if (i % 40 == 20) set_bank(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
         do_acc(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                16'($urandom), 32'($urandom), 32'($urandom));
      end
      repeat (3) @(negedge clk);
      chk(mon_bad == 0, "R11", "false edge on shared pin", 32'(mon_bad), 32'h0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule